// File: doc/BRIEF.md
# I2C Register Access Target

This block is an I2C target that gives an external bus controller read and write access to a space of 8-bit registers. It samples both bus lines with the system clock and passes each line through a glitch filter sized in clock cycles. It recognises start, repeated start and stop conditions and then walks a byte-level protocol. The block never drives SCL. It pulls SDA low through an output enable and never drives it high.

A transaction opens with a 7-bit device address. The upper four bits of that address are fixed and the lower three come from strap inputs, which are sampled once after reset. Two bytes follow that set a 16-bit register pointer, high byte first. Any further bytes are written at the pointer, and the pointer steps forward after each one. To read, the controller writes the pointer, issues a repeated start and sends the address again with the read direction. The block then returns bytes from the pointer onward until the controller answers with a no-acknowledge.

The register space is outside the block. It connects through a flat port made of an address, write data, a one-cycle write strobe and combinational read data.

Top module: `i2c_regport`

## Requirements
- R1: While reset is asserted and directly after it is released, `sda_oe_o` is 0, `reg_we_o` is 0 and `reg_addr_o` is 0.
- R2: The device address is binary 1001 followed by the three captured strap bits. The first byte after a start carries this address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). A matching address byte is acknowledged. A non-matching one is not acknowledged, and no later byte before the next start is acknowledged or written.
- R3: The strap inputs are captured on the first clock after reset is released. Later changes on them have no effect on address matching.
- R4: After a write-direction address byte, the next two bytes load the pointer, high byte first. Each byte after that produces exactly one `reg_we_o` pulse of one clock, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the received byte.
- R5: The pointer increments by one after every written byte, and the carry runs across all 16 bits.
- R6: After a repeated start with a read-direction address byte, the block sends `reg_rdata_i` for the current pointer, MSB first. The pointer increments by one after each byte sent. The next byte is sent when the controller acknowledges.
- R7: A no-acknowledge from the controller ends the read. SDA stays released through any further SCL pulses until the next start or stop.
- R8: A start or stop at any bit position drops the partially received byte. A repeated start begins a new address byte.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` clocks (5 clocks, which is 50 ns at 100 MHz) is ignored.
- R10: With a 100 MHz clock, transfers work at a 100 kHz bus rate and at a 400 kHz bus rate.
- R11: The block acknowledges each byte it accepts by pulling SDA low during the ninth SCL pulse. `sda_oe_o` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Low device-address bits, captured after reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr_o | output | 16 | Register pointer |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o` |

## Verification
The hardest situations to create are those where the bus itself misbehaves. One is a sub-threshold spike on SCL while it is low, which would add a phantom bit if it got through. Another is a short dip on SDA while SCL is high, which would look like a start and abort the write. The bench builds both by XOR-ing a pulse of four clocks into the line inside one chosen bit of a real write, then confirms that exactly one correct register write results. A start in the middle of a byte, and SCL pulses sent after a read no-acknowledge, are produced the same way: bus-level tasks are cut short or extended, and the bench watches the data line and the write log.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTRH,
    ST_PTRL,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } rp_state_e;

  localparam logic [3:0] BIT_ACK = 4'd8;
  localparam logic [3:0] BIT_END = 4'd9;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_i};
  end

  // a new level is taken only after FILT_CYC differing samples in a row
  always_comb begin
    cnt_d = '0;
    out_d = out_q;
    if (sync_q[1] != out_q) begin
      if (cnt_q == CNT_LAST) out_d = sync_q[1];
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign line_o = out_q;

  // R9
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> ($past(sync_q[1], 1) == out_q && $past(sync_q[1], 2) == out_q));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int         FILT_CYC = 5,
  parameter int         STRAP_W  = 3,
  parameter logic [6:0] DEV_BASE = 7'h48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [15:0]        reg_addr_o,
  output logic [7:0]         reg_wdata_o,
  output logic               reg_we_o,
  input  logic [7:0]         reg_rdata_i
);
  localparam int DATA_W = 8;
  localparam int PTR_W  = 2 * DATA_W;
  localparam int DEV_W  = 7;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // line filters: index 0 is SCL, index 1 is SDA
  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_s), .line_i(raw[g]), .line_o(filt[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  logic scl_rise, scl_fall, start_det, stop_det;
  i2c_bus_events u_evt (
    .clk(clk), .rst_n(rst_s), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // strap capture, once after reset
  logic               strap_cap_q;
  logic [STRAP_W-1:0] strap_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      strap_cap_q <= 1'b0;
      strap_q     <= '0;
    end else if (!strap_cap_q) begin
      strap_cap_q <= 1'b1;
      strap_q     <= strap_i;
    end
  end

  logic [DEV_W-1:0] dev_addr;
  assign dev_addr = {DEV_BASE[DEV_W-1:STRAP_W], strap_q};

  rp_state_e         state_q, state_d;
  logic [3:0]        bit_q, bit_d;
  logic [DATA_W-1:0] rx_q, rx_d, tx_q, tx_d, wdat_q, wdat_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              oe_q, oe_d, rw_q, rw_d, ack_q, ack_d, we_q, we_d;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    ack_d   = ack_q;
    we_d    = 1'b0;
    wdat_d  = wdat_q;
    if (start_det) begin
      state_d = ST_DEV;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (state_q != ST_IDLE && state_q != ST_SKIP) begin
      if (scl_rise) begin
        if (bit_q < BIT_ACK) begin
          rx_d  = {rx_q[DATA_W-2:0], sda_f};
          bit_d = bit_q + 4'd1;
        end else if (bit_q == BIT_ACK) begin
          bit_d = BIT_END;
          if (state_q == ST_RDAT) begin
            ack_d = ~sda_f;
            ptr_d = ptr_q + 1'b1;
          end
        end
      end else if (scl_fall) begin
        if (bit_q == BIT_ACK) begin
          unique case (state_q)
            ST_DEV: begin
              if (rx_q[DATA_W-1:1] == dev_addr) begin
                oe_d = 1'b1;
                rw_d = rx_q[0];
              end else begin
                state_d = ST_SKIP;
              end
            end
            ST_PTRH: begin oe_d = 1'b1; ptr_d[PTR_W-1:DATA_W] = rx_q; end
            ST_PTRL: begin oe_d = 1'b1; ptr_d[DATA_W-1:0]     = rx_q; end
            ST_WDAT: begin oe_d = 1'b1; we_d = 1'b1; wdat_d = rx_q; end
            default: oe_d = 1'b0;
          endcase
        end else if (bit_q == BIT_END) begin
          bit_d = '0;
          oe_d  = 1'b0;
          unique case (state_q)
            ST_DEV: begin
              if (rw_q) begin
                state_d = ST_RDAT;
                tx_d    = reg_rdata_i;
                oe_d    = ~reg_rdata_i[DATA_W-1];
              end else begin
                state_d = ST_PTRH;
              end
            end
            ST_PTRH: state_d = ST_PTRL;
            ST_PTRL: state_d = ST_WDAT;
            ST_WDAT: ptr_d   = ptr_q + 1'b1;
            ST_RDAT: begin
              if (ack_q) begin
                tx_d = reg_rdata_i;
                oe_d = ~reg_rdata_i[DATA_W-1];
              end else begin
                state_d = ST_SKIP;
              end
            end
            default: ;
          endcase
        end else if (state_q == ST_RDAT && bit_q != 4'd0) begin
          tx_d = {tx_q[DATA_W-2:0], 1'b0};
          oe_d = ~tx_q[DATA_W-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      we_q    <= 1'b0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      ack_q   <= ack_d;
      we_q    <= we_d;
      wdat_q  <= wdat_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdat_q;
  assign reg_we_o    = we_q;

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    reg_we_o |=> !reg_we_o);

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_SKIP) |-> !sda_oe_o);

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(sda_oe_o) |-> !$past(scl_f));

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (strap_cap_q && $past(strap_cap_q)) |-> $stable(strap_q));

  // R8
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    bit_q <= BIT_END);

  // R6
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_RDAT && $past(state_q) == ST_RDAT && !$stable(ptr_q))
      |-> ptr_q == $past(ptr_q) + 1'b1);

endmodule

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb_top;

  typedef struct packed {
    logic        rd;
    logic        hit;
    logic [6:0]  dev;
    logic [15:0] ptr;
    logic [7:0]  d0;
    logic [2:0]  n;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{rd:1'b0, hit:1'b1, dev:7'h4D, ptr:16'h1234, d0:8'h3C, n:3'd1},
    '{rd:1'b0, hit:1'b1, dev:7'h4D, ptr:16'h12FF, d0:8'h80, n:3'd3},
    '{rd:1'b0, hit:1'b0, dev:7'h4A, ptr:16'h0010, d0:8'h77, n:3'd2},
    '{rd:1'b1, hit:1'b1, dev:7'h4D, ptr:16'hABFE, d0:8'h00, n:3'd3},
    '{rd:1'b1, hit:1'b0, dev:7'h0D, ptr:16'h0300, d0:8'h00, n:3'd1},
    '{rd:1'b0, hit:1'b1, dev:7'h4D, ptr:16'h0000, d0:8'hFF, n:3'd2}
  };
  localparam int GL = 4;

  logic        clk, rst_n;
  logic [2:0]  strap;
  logic        m_scl, m_sda, scl_gl, sda_gl;
  logic        scl_bus, sda_bus;
  logic        sda_oe, reg_we;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'hA5;
  endfunction

  assign scl_bus   = m_scl ^ scl_gl;
  assign sda_bus   = (m_sda ^ sda_gl) & ~sda_oe;
  assign reg_rdata = exp_rd(reg_addr);

  i2c_regport dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl_bus), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk, n_fail, q, wn;
  logic done, mon_en, oe_seen;
  logic [15:0] wa [0:31];
  logic [7:0]  wd [0:31];

  always @(negedge clk) begin
    if (reg_we && wn < 32) begin
      wa[wn] = reg_addr;
      wd[wn] = reg_wdata;
      wn++;
    end
    if (mon_en && sda_oe) oe_seen = 1'b1;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out_g(input logic b, input int g);
    m_sda = b;
    if (g == 1) begin
      wait_c(q / 2); scl_gl = 1'b1; wait_c(GL); scl_gl = 1'b0; wait_c(q - q / 2 - GL);
    end else wait_c(q);
    m_scl = 1'b1;
    if (g == 2) begin
      wait_c(q); sda_gl = 1'b1; wait_c(GL); sda_gl = 1'b0; wait_c(q - GL);
    end else wait_c(2 * q);
    m_scl = 1'b0;
    wait_c(q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wait_c(q);
    m_scl = 1'b1; wait_c(q);
    b = sda_bus;  wait_c(q);
    m_scl = 1'b0; wait_c(q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_c(q);
    m_scl = 1'b1; wait_c(q);
    m_sda = 1'b0; wait_c(q);
    m_scl = 1'b0; wait_c(q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_c(q);
    m_scl = 1'b1; wait_c(q);
    m_sda = 1'b1; wait_c(2 * q);
  endtask

  task automatic send_byte_g(input logic [7:0] b, output logic ack, input int g);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out_g(b[i], (i == 4) ? g : 0);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_byte_g(b, ack, 0);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out_g(~give_ack, 0);
  endtask

  initial begin
    done = 1'b0;
    repeat (195000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
    end
  end

  initial begin
    vec_t v;
    logic ack;
    logic [7:0] d;
    int w0;
    n_chk = 0; n_fail = 0; wn = 0; q = 63;
    mon_en = 1'b0; oe_seen = 1'b0;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; scl_gl = 1'b0; sda_gl = 1'b0;
    strap = 3'b101;
    wait_c(10);
    rst_n = 1'b1;
    wait_c(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", 32'(sda_oe), 0);
    chk(reg_we == 1'b0, "R1", "reg_we after reset", 32'(reg_we), 0);
    chk(reg_addr == 16'h0, "R1", "pointer after reset", 32'(reg_addr), 0);

    // R3: strap pins move after capture; latched value 101 still decides
    strap = 3'b010;
    wait_c(5);
    bus_start();
    send_byte({7'h4D, 1'b0}, ack);
    chk(ack == 1'b1, "R3", "captured strap address ack", 32'(ack), 1);
    bus_stop();

    // table of transactions
    for (int i = 0; i < NV; i++) begin
      v  = VECS[i];
      w0 = wn;
      bus_start();
      send_byte({v.dev, 1'b0}, ack);
      chk(ack == v.hit, "R2", "device address ack", 32'(ack), 32'(v.hit));
      send_byte(v.ptr[15:8], ack);
      chk(ack == v.hit, "R11", "pointer high ack", 32'(ack), 32'(v.hit));
      send_byte(v.ptr[7:0], ack);
      chk(ack == v.hit, "R11", "pointer low ack", 32'(ack), 32'(v.hit));
      if (!v.rd) begin
        for (int k = 0; k < int'(v.n); k++) begin
          send_byte(8'(v.d0 + k), ack);
          chk(ack == v.hit, "R11", "data byte ack", 32'(ack), 32'(v.hit));
        end
        bus_stop();
        chk(wn - w0 == (v.hit ? int'(v.n) : 0), "R4", "write strobe count",
            32'(wn - w0), v.hit ? 32'(v.n) : 0);
        if (v.hit) begin
          for (int k = 0; k < int'(v.n); k++) begin
            chk(wa[w0 + k] == 16'(v.ptr + k), "R5", "write address",
                32'(wa[w0 + k]), 32'(16'(v.ptr + k)));
            chk(wd[w0 + k] == 8'(v.d0 + k), "R4", "write data",
                32'(wd[w0 + k]), 32'(8'(v.d0 + k)));
          end
        end
      end else begin
        if (v.hit) begin
          bus_start();
          send_byte({v.dev, 1'b1}, ack);
          chk(ack == 1'b1, "R6", "read address ack", 32'(ack), 1);
          for (int k = 0; k < int'(v.n); k++) begin
            recv_byte(d, k != int'(v.n) - 1);
            chk(d == exp_rd(16'(v.ptr + k)), "R6", "read data",
                32'(d), 32'(exp_rd(16'(v.ptr + k))));
          end
        end
        bus_stop();
        chk(wn == w0, "R2", "no write on read/mismatch", 32'(wn - w0), 0);
      end
    end

    // R9: SCL spike while low and SDA dip while high inside a write
    w0 = wn;
    bus_start();
    send_byte({7'h4D, 1'b0}, ack);
    send_byte_g(8'h00, ack, 0);
    send_byte_g(8'h40, ack, 1);
    send_byte_g(8'h96, ack, 2);
    chk(ack == 1'b1, "R9", "ack after glitches", 32'(ack), 1);
    bus_stop();
    chk(wn - w0 == 1, "R9", "write count with glitches", 32'(wn - w0), 1);
    chk(wa[w0] == 16'h0040 && wd[w0] == 8'h96, "R9", "glitch write addr/data",
        {wa[w0], 8'h0, wd[w0]}, 32'h0040_0096);

    // R8: repeated start after three bits of a pointer byte
    w0 = wn;
    bus_start();
    send_byte({7'h4D, 1'b0}, ack);
    bit_out_g(1'b1, 0); bit_out_g(1'b0, 0); bit_out_g(1'b1, 0);
    bus_start();
    send_byte({7'h4D, 1'b0}, ack);
    chk(ack == 1'b1, "R8", "address ack after restart", 32'(ack), 1);
    send_byte(8'h01, ack);
    send_byte(8'h00, ack);
    send_byte(8'h5A, ack);
    bus_stop();
    chk(wn - w0 == 1 && wa[w0] == 16'h0100 && wd[w0] == 8'h5A, "R8",
        "write after aborted byte", {wa[w0], 8'h0, wd[w0]}, 32'h0100_005A);

    // R7: NACK ends a read, further clocks see a released line
    bus_start();
    send_byte({7'h4D, 1'b0}, ack);
    send_byte(8'h20, ack);
    send_byte(8'h00, ack);
    bus_start();
    send_byte({7'h4D, 1'b1}, ack);
    recv_byte(d, 1'b0);
    chk(d == exp_rd(16'h2000), "R6", "single read byte", 32'(d), 32'(exp_rd(16'h2000)));
    oe_seen = 1'b0;
    mon_en  = 1'b1;
    recv_byte(d, 1'b0);
    mon_en  = 1'b0;
    chk(oe_seen == 1'b0, "R7", "sda_oe after nack", 32'(oe_seen), 0);
    chk(d == 8'hFF, "R7", "bus level after nack", 32'(d), 32'hFF);
    bus_stop();

    // R10: standard-rate write
    q  = 250;
    w0 = wn;
    bus_start();
    send_byte({7'h4D, 1'b0}, ack);
    send_byte(8'h07, ack);
    send_byte(8'h77, ack);
    send_byte(8'h11, ack);
    chk(ack == 1'b1, "R10", "slow-rate data ack", 32'(ack), 1);
    bus_stop();
    chk(wn - w0 == 1 && wa[w0] == 16'h0777 && wd[w0] == 8'h11, "R10",
        "slow-rate write", {wa[w0], 8'h0, wd[w0]}, 32'h0777_0011);
    q = 63;

    // R3: the live strap value is not the device address
    bus_start();
    send_byte({7'h4A, 1'b0}, ack);
    chk(ack == 1'b0, "R3", "new strap value ignored", 32'(ack), 0);
    bus_stop();

    done = 1'b1;
    report();
  end

endmodule